// File: doc/BRIEF.md
# SPI Master Burst Shift Engine

This block is the serial core of an SPI master. Software writes a 32-bit transfer-control word that picks the clock polarity and phase, the bit order, one of four chip-select lines with its polarity, manual or automatic chip-select handling, and whether received bytes are thrown away while transmit data goes out. Setting the start bit launches a burst. Three 24-bit counts size the burst: the total number of bytes exchanged, how many of them carry data taken from the transmit FIFO, and how many leading bytes form the single-transmit window. Received data is dropped inside that window when the discard bit is set.

A separate divider supplies a one-cycle `sck_tick` strobe once per half SCK period. The FIFOs live outside the block. The transmit side is first-word-fall-through: the engine reads `tx_data` while it pulses `tx_pop`. The receive side takes a byte on every `rx_push`. At the end of the burst the engine pulses `done` and clears the start bit, so software can also poll for completion.

Top module: `spi_burst_engine`

## Requirements
- R1: After reset the control word reads 0, `sck` is 0, all four `cs_o` lines are high, and `rx_push`, `tx_pop` and `done` are low.
- R2: Control bit 1 (polarity) sets the idle level of `sck`. Each byte takes 16 `sck` edges, one per `sck_tick`. With phase bit 0 clear, MISO is sampled on the first edge of each bit pair and MOSI changes on the second edge. With phase bit 0 set, MOSI changes on the first edge and MISO is sampled on the second.
- R3: With control bit 12 clear, each byte is shifted most-significant bit first. With it set, each byte is shifted least-significant bit first. The same order applies in both directions.
- R4: Bytes with index below the transmit count each pop one FIFO entry and send it. Every later byte of the burst is sent as 0x00 and pops nothing. `tx_pop` is never asserted while `tx_empty` is high.
- R5: Writing the control word with bit 31 set starts a burst of exactly the total count of bytes. When the burst ends, `done` pulses for one cycle and bit 31 reads back 0.
- R6: With control bit 8 set, bytes with index below the single-transmit count produce no `rx_push`. Every other byte pushes the byte received on MISO.
- R7: Control bits 5:4 select one of the four chip-select lines. Control bit 2 gives the active level: 0 means active-low, 1 means active-high. Unselected lines stay at the inactive level. In automatic mode the selected line is active from one half period before the first edge until one half period after the last edge.
- R8: With control bit 6 set, the selected chip-select line drives the value of control bit 7 directly, whether or not a burst is running.
- R9: If the transmit FIFO is empty when a data byte is due, the engine holds `sck` at its idle level and waits, then continues once data arrives.
- R10: While bit 31 reads 1, writes to the control word are ignored.
- R11: A burst with a total count of 0 produces no `sck` edges and no pushes, and still pulses `done` and clears bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control-word write strobe |
| ctl_wdata | input | 32 | Control-word write data |
| ctl_rd | output | 32 | Control-word read-back; bit 31 is the busy/start flag |
| total_cnt | input | 24 | Bytes in the burst |
| tx_cnt | input | 24 | Leading bytes that take data from the transmit FIFO |
| stx_cnt | input | 24 | Leading bytes in the single-transmit (discard) window |
| sck_tick | input | 1 | Half-period strobe from the clock divider |
| tx_data | input | 8 | Head entry of the transmit FIFO |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_pop | output | 1 | Consume the head entry of the transmit FIFO |
| rx_data | output | 8 | Received byte |
| rx_push | output | 1 | Write `rx_data` into the receive FIFO |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_o | output | 4 | Chip-select lines |
| done | output | 1 | One-cycle burst-complete pulse |

## Verification
Some properties are checked on every cycle. At most one chip-select line ever leaves the inactive level. `tx_pop` never occurs with an empty FIFO. `sck` rests at the polarity level whenever no burst is running. The control fields hold still while busy. `done` is a single-cycle pulse that leaves the start bit clear.

Other behaviours need a slave model and are shown only by the bench scenarios: the bit order, the sample and shift edges of each mode, the zero fill after the transmit count, the discard window, the stall on an empty FIFO and the zero-length burst. For these the bench compares the bytes on the wire and the pushed bytes against values it computes itself.

// File: rtl/spi_burst_engine.sv
module spi_burst_engine #(
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_we,
  input  logic [31:0]   ctl_wdata,
  output logic [31:0]   ctl_rd,
  input  logic [CW-1:0] total_cnt,
  input  logic [CW-1:0] tx_cnt,
  input  logic [CW-1:0] stx_cnt,
  input  logic          sck_tick,
  input  logic [7:0]    tx_data,
  input  logic          tx_empty,
  output logic          tx_pop,
  output logic [7:0]    rx_data,
  output logic          rx_push,
  output logic          sck,
  output logic          mosi,
  input  logic          miso,
  output logic [3:0]    cs_o,
  output logic          done
);
  localparam logic [CW-1:0] ONE = CW'(1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_TRAIL} st_t;

  st_t           st;
  logic [31:0]   ctl_q;
  logic [3:0]    h;
  logic          loaded, act, mosi_q;
  logic [7:0]    txb, rxb, rx_next;
  logic [CW-1:0] nbyte, tot, txn, stn;

  wire cpha  = ctl_q[0];
  wire cpol  = ctl_q[1];
  wire cspol = ctl_q[2];
  wire [1:0] csi = ctl_q[5:4];
  wire man   = ctl_q[6];
  wire mlev  = ctl_q[7];
  wire disc  = ctl_q[8];
  wire lsb   = ctl_q[12];
  wire go    = ctl_q[31];

  wire       need_tx  = nbyte < txn;
  wire       can_load = (st == S_RUN) && !loaded && (!need_tx || !tx_empty);
  wire       edge_now = (st == S_RUN) && loaded && sck_tick;
  wire       lead     = ~h[0];
  wire       samp     = lead ^ cpha;
  wire [2:0] k        = h[3:1];
  wire [2:0] idx      = lsb ? k : 3'd7 - k;
  wire [2:0] nidx     = lsb ? k + 3'd1 : 3'd6 - k;
  wire [7:0] ld_byte  = need_tx ? tx_data : 8'h00;

  assign tx_pop = can_load && need_tx;
  assign ctl_rd = ctl_q;
  assign sck    = cpol ^ act;
  assign mosi   = mosi_q;

  always_comb begin
    rx_next = rxb;
    if (samp) rx_next[idx] = miso;
  end

  for (genvar i = 0; i < 4; i++) begin : g_cs
    assign cs_o[i] = (csi != 2'(i)) ? ~cspol :
                     man            ? mlev   :
                     (st != S_IDLE) ? cspol  : ~cspol;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ctl_q <= '0; h <= '0; loaded <= 1'b0; act <= 1'b0;
      mosi_q <= 1'b0; txb <= '0; rxb <= '0; nbyte <= '0;
      tot <= '0; txn <= '0; stn <= '0;
      rx_push <= 1'b0; rx_data <= '0; done <= 1'b0;
    end else begin
      rx_push <= 1'b0;
      done    <= 1'b0;
      if (ctl_we && !go) ctl_q <= ctl_wdata;
      case (st)
        S_IDLE: if (go && sck_tick) begin
          tot <= total_cnt; txn <= tx_cnt; stn <= stx_cnt;
          nbyte <= '0; h <= '0; loaded <= 1'b0; act <= 1'b0;
          st <= (total_cnt == '0) ? S_TRAIL : S_RUN;
        end
        S_RUN: begin
          if (can_load) begin
            txb <= ld_byte; loaded <= 1'b1; h <= '0;
            if (!cpha) mosi_q <= lsb ? ld_byte[0] : ld_byte[7];
          end else if (edge_now) begin
            act <= lead;
            if (samp) rxb <= rx_next;
            if (cpha && lead) mosi_q <= txb[idx];
            if (!cpha && !lead && h != 4'd15) mosi_q <= txb[nidx];
            h <= h + 4'd1;
            if (h == 4'd15) begin
              loaded  <= 1'b0;
              nbyte   <= nbyte + ONE;
              rx_data <= rx_next;
              rx_push <= !(disc && nbyte < stn);
              if (nbyte + ONE == tot) st <= S_TRAIL;
            end
          end
        end
        S_TRAIL: if (sck_tick) begin
          st <= S_IDLE; done <= 1'b1; ctl_q[31] <= 1'b0;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_cs_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs_o ^ {4{~cspol}}));
  assert_pop_nonempty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> !tx_empty);
  assert_sck_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> (sck == cpol));
  assert_ctl_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> $stable(ctl_q[30:0]));
  assert_done_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!go && !$past(done)));
  assert_stall_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && !loaded && need_tx && tx_empty) |=> $stable(sck));
endmodule

// File: tb/spi_burst_engine_tb.sv
module spi_burst_engine_tb_top;
  logic        clk = 0, rst_n = 0;
  logic        ctl_we = 0;
  logic [31:0] ctl_wdata = 0;
  logic [31:0] ctl_rd;
  logic [23:0] total_cnt = 0, tx_cnt = 0, stx_cnt = 0;
  logic        sck_tick;
  logic [7:0]  tx_data;
  logic        tx_empty, tx_pop;
  logic [7:0]  rx_data;
  logic        rx_push, sck, mosi, done;
  logic        miso = 0;
  logic [3:0]  cs_o;

  always #4 clk = ~clk;

  spi_burst_engine dut_i (.*);

  int total = 0, bad = 0, cyc = 0;
  logic [1:0] tickc = 0;
  int rd = 0, rd_base = 0, avail = 0;
  logic [7:0] seed = 0;
  always @(posedge clk) begin
    tickc <= tickc + 2'd1;
    if (tx_pop) rd <= rd + 1;
  end
  assign sck_tick = (tickc == 2'd3);

  function automatic logic [7:0] fdat(int i, logic [7:0] s);
    return 8'hA5 ^ 8'(i * 37) ^ s;
  endfunction
  function automatic logic [7:0] spat(int i);
    return 8'h3C + 8'(i * 29);
  endfunction

  assign tx_data  = fdat(rd - rd_base, seed);
  assign tx_empty = (rd - rd_base) >= avail;

  bit         armed = 0, cur_cpha = 0, cur_lsb = 0;
  logic       psck = 0;
  int         seen = 0, dones = 0, rxn = 0, cs_bad = 0;
  logic [3:0] cs_exp = 4'hF;
  logic [7:0] mosi_got [16];
  logic [7:0] rx_got [16];

  always @(negedge clk) begin
    cyc++;
    if (armed && sck !== psck) begin
      int r, b, j;
      b = seen / 16; r = seen % 16;
      if (cur_cpha ? (r % 2 == 1) : (r % 2 == 0)) begin
        j = r / 2;
        if (b < 16) mosi_got[b][cur_lsb ? j : 7 - j] = mosi;
      end
      if (cs_o !== cs_exp) cs_bad++;
      seen++;
    end
    psck = sck;
    begin
      int r2, j2;
      logic [7:0] v;
      r2 = seen % 16;
      j2 = cur_cpha ? ((r2 == 0) ? 0 : (r2 - 1) / 2) : r2 / 2;
      v = spat(seen / 16);
      miso = v[cur_lsb ? j2 : 7 - j2];
    end
    if (rx_push && rxn < 16) begin rx_got[rxn] = rx_data; rxn++; end
    else if (rx_push) rxn++;
    if (done) dones++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s act=%0h exp=%0h", req, act, exp); end
  endtask

  task automatic wr(input logic [31:0] v);
    @(negedge clk); ctl_we = 1; ctl_wdata = v;
    @(negedge clk); ctl_we = 0;
  endtask

  function automatic logic [31:0] mk(bit cpha, bit cpol, bit spol, logic [1:0] csi,
                                     bit man, bit mlev, bit disc, bit lsb);
    return {19'd0, lsb, 3'd0, disc, mlev, man, csi, 1'b0, spol, cpol, cpha};
  endfunction

  task automatic burst(input logic [31:0] cfg, input int tot, input int txc, input int stc,
                       input int av0, input bit stall, input bit busy_wr);
    int pops, t, exp_rx, k2, nb;
    bit ok;
    total_cnt = 24'(tot); tx_cnt = 24'(txc); stx_cnt = 24'(stc);
    seed = 8'(cfg[7:0] + 8'(tot));
    wr(cfg);
    repeat (2) @(negedge clk);
    rd_base = rd; avail = av0;
    cur_cpha = cfg[0]; cur_lsb = cfg[12];
    cs_exp = {4{~cfg[2]}}; cs_exp[cfg[5:4]] = cfg[2];
    seen = 0; dones = 0; rxn = 0; cs_bad = 0; psck = sck; armed = 1;
    for (int i = 0; i < 16; i++) mosi_got[i] = 8'h00;
    wr(cfg | 32'h8000_0000);
    if (busy_wr) begin
      repeat (10) @(negedge clk);
      wr(cfg ^ 32'h0000_1003);
    end
    if (stall) begin
      t = 0;
      while (seen < 16 && t < 2000) begin @(negedge clk); t++; end
      repeat (60) @(negedge clk);
      t = seen;
      repeat (60) @(negedge clk);
      chk(seen == 16 && t == 16 && sck == cfg[1], "R9 stall", seen, 16);
      avail = tot;
    end
    t = 0;
    while (dones == 0 && t < 6000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
    armed = 0;
    nb = (tot < 16) ? tot : 16;
    ok = 1;
    for (int i = 0; i < nb; i++)
      if (mosi_got[i] !== ((i < txc) ? fdat(i, seed) : 8'h00)) ok = 0;
    chk(ok, "R3/R4 mosi bytes", mosi_got[0], (txc > 0) ? fdat(0, seed) : 0);
    pops = rd - rd_base;
    chk(pops == ((txc < tot) ? txc : tot), "R4 pops", pops, (txc < tot) ? txc : tot);
    chk(seen == 16 * tot, "R2 edge count", seen, 16 * tot);
    exp_rx = 0; ok = 1; k2 = 0;
    for (int i = 0; i < tot; i++)
      if (!(cfg[8] && i < stc)) begin
        if (k2 < 16 && rx_got[k2] !== spat(i)) ok = 0;
        k2++; exp_rx++;
      end
    chk(rxn == exp_rx, "R6 rx push count", rxn, exp_rx);
    chk(ok, "R2/R3 rx bytes", rx_got[0], spat(0));
    chk(dones == 1 && ctl_rd[31] == 1'b0, "R5 done/start clear", dones, 1);
    chk(ctl_rd[30:0] == cfg[30:0], "R10 ctl kept", ctl_rd, cfg);
    chk(cs_bad == 0 && cs_o == {4{~cfg[2]}}, "R7 chip select", cs_bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ctl_rd == 0 && sck == 0 && cs_o == 4'hF && !rx_push && !tx_pop && !done,
        "R1 reset", {cs_o, 3'b0, sck}, 32'hF0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    for (int m = 0; m < 8; m++)
      burst(mk(m[0], m[1], m[0] ^ m[1], 2'(m), 0, 0, 0, m[2]), 3, 2, 2, 3, 0, 0);
    burst(mk(0, 0, 0, 2'd1, 0, 0, 1, 0), 4, 4, 2, 4, 0, 1);
    burst(mk(1, 1, 0, 2'd3, 0, 0, 1, 1), 5, 3, 1, 5, 0, 0);
    burst(mk(1, 0, 1, 2'd0, 0, 0, 0, 0), 3, 3, 0, 1, 1, 0);
    burst(mk(0, 1, 0, 2'd2, 0, 0, 0, 0), 0, 0, 0, 0, 0, 0);
    chk(seen == 0 && rxn == 0, "R11 zero burst", seen, 0);
    wr(mk(0, 0, 0, 2'd2, 1, 0, 0, 0));
    @(negedge clk);
    chk(cs_o == 4'b1011, "R8 manual low", cs_o, 4'b1011);
    wr(mk(0, 0, 1, 2'd2, 1, 1, 0, 0));
    @(negedge clk);
    chk(cs_o == 4'b0100, "R8 manual high", cs_o, 4'b0100);
    wr(mk(0, 0, 0, 2'd1, 1, 1, 0, 0));
    @(negedge clk);
    chk(cs_o == 4'b1111, "R8 manual level on R7 index", cs_o, 4'b1111);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule